// File: doc/BRIEF.md
# Coherent Snapshot Reader for a Wide Free-Running Counter

This block holds a wide up-counter that advances by one on every clock cycle in which the tick-enable input is high. Its purpose is timekeeping and busy-wait delays. The counter is wider than the 32-bit register bus, so reading it as two halves could give a torn value. To prevent that, a snapshot handshake sits in front of it.

Software sets a request flag in the control word. The block then captures the counter into a staging register. After a fixed, parameterized number of cycles it moves that staged value into a holding pair and lowers the flag. Software polls the flag until it reads back zero. It then fetches the two 32-bit halves of the holding pair, in any order. The counter itself never stops.

Top module: `wide_snap_counter`

## Requirements
- R1: After synchronous reset, the counter, the staging value, the holding pair and the request flag are all zero. Reads of the control word (offset 0xA0), the low half (0xA4) and the high half (0xA8) all return 0.
- R2: The counter rises by exactly one on each clock cycle in which `tick_en` is high, and holds its value when `tick_en` is low.
- R3: A write to offset 0xA0 with data bit 1 set, made while no request is pending, raises the request flag. The flag reads back as bit 1 of offset 0xA0. It reads 1 for exactly `LATCH_DELAY` back-to-back polls and reads 0 afterwards.
- R4: The snapshot equals the counter value in the cycle of the accepted request write. Offset 0xA4 returns bits 31:0 of the snapshot. Offset 0xA8 returns bits 63:32, zero-extended when the counter is narrower than 64 bits.
- R5: The holding pair changes only when a request completes. Repeated reads of either half, in either order and while the counter keeps running, return the same coherent value.
- R6: A write to offset 0xA0 with data bit 1 clear has no effect. The flag stays 0 and the holding pair is unchanged.
- R7: A request write made while the flag is already set is ignored. The snapshot still holds the value of the first request.
- R8: The counter wraps from all ones to zero and keeps counting.
- R9: Read data and `rd_valid` appear in the cycle after `rd_en`. `rd_valid` is low in every other cycle, and offsets with no register behind them read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the counter and the bus |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advance enable, high for one count per cycle |
| bus_addr | input | 8 | Register byte offset |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 32 | Write data; only bit 1 at offset 0xA0 has meaning |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | 32 | Registered read data |
| bus_rd_valid | output | 1 | High in the cycle after a read strobe |

## Verification
The bench counts how many consecutive polls see the flag set. A design that clears the flag one cycle early or late fails that count, and so does a design that lets a second request restart the delay. It sends a second request into the pending window and a request write with bit 1 clear. A design that re-captures on either of these returns a later counter value instead of the first snapshot. It stops the ticks between two requests to catch a counter that runs without enable, and it re-reads the halves in swapped order after more ticks to catch a holding pair that follows the live counter. A second, 8-bit instance is run past its wrap point, where a design that saturates or drops the carry gives the wrong low byte.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  localparam int BUS_W    = 32;
  localparam int ADDR_W   = 8;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 8'hA0;
  localparam logic [ADDR_W-1:0] OFF_LO   = 8'hA4;
  localparam logic [ADDR_W-1:0] OFF_HI   = 8'hA8;
  localparam int REQ_BIT  = 1;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_LO   = 2'd2,
    SEL_HI   = 2'd3
  } rd_sel_e;

  function automatic rd_sel_e decode_off(input logic [ADDR_W-1:0] a);
    case (a)
      OFF_CTRL: return SEL_CTRL;
      OFF_LO:   return SEL_LO;
      OFF_HI:   return SEL_HI;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/wsc_tick_counter.sv
module wsc_tick_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  output logic [CNT_W-1:0] count_q
);
  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else if (tick_en) count_q <= count_q + 1'b1;
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    tick_en |=> count_q == $past(count_q) + 1'b1);
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(count_q));
  assert_count_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (tick_en && count_q == '1) |=> count_q == '0);
endmodule

// File: rtl/wsc_snap_ctrl.sv
module wsc_snap_ctrl #(
  parameter int CNT_W       = 64,
  parameter int LATCH_DELAY = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_wr,
  input  logic [CNT_W-1:0] count_in,
  output logic             pending_q,
  output logic [CNT_W-1:0] hold_q
);
  localparam int DLY_W = $clog2(LATCH_DELAY + 1);
  localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(LATCH_DELAY);

  logic [DLY_W-1:0] dly_q;
  logic [CNT_W-1:0] stage_q;
  logic             accept;

  assign accept = req_wr && !pending_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
      dly_q     <= '0;
      stage_q   <= '0;
      hold_q    <= '0;
    end else if (!pending_q) begin
      if (accept) begin
        pending_q <= 1'b1;
        dly_q     <= DLY_LOAD;
        stage_q   <= count_in;
      end
    end else if (dly_q == DLY_W'(1)) begin
      hold_q    <= stage_q;
      pending_q <= 1'b0;
      dly_q     <= '0;
    end else begin
      dly_q <= dly_q - 1'b1;
    end
  end

  assert_accept_sets_R3: assert property (@(posedge clk) disable iff (rst)
    accept |=> pending_q);
  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (rst)
    !pending_q |=> $stable(hold_q));
  assert_busy_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (pending_q && req_wr) |=> $stable(stage_q));
endmodule

// File: rtl/wsc_reg_if.sv
module wsc_reg_if
  import wsc_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              req_bit,
  input  logic              rd_en,
  input  logic              pending,
  input  logic [CNT_W-1:0]  hold,
  output logic              req_wr,
  output logic [BUS_W-1:0]  rd_data,
  output logic              rd_valid
);
  localparam int LO_W = (CNT_W < BUS_W) ? CNT_W : BUS_W;

  logic [BUS_W-1:0] lo_word;
  logic [BUS_W-1:0] hi_word;
  logic [BUS_W-1:0] ctrl_word;
  logic [BUS_W-1:0] rd_next;

  assign req_wr = wr_en && req_bit && (decode_off(addr) == SEL_CTRL);

  always_comb begin
    lo_word = '0;
    lo_word[LO_W-1:0] = hold[LO_W-1:0];
  end

  generate
    if (CNT_W > BUS_W) begin : g_wide
      always_comb begin
        hi_word = '0;
        hi_word[CNT_W-BUS_W-1:0] = hold[CNT_W-1:BUS_W];
      end
    end else begin : g_narrow
      assign hi_word = '0;
    end
  endgenerate

  always_comb begin
    ctrl_word = '0;
    ctrl_word[REQ_BIT] = pending;
  end

  always_comb begin
    case (decode_off(addr))
      SEL_CTRL: rd_next = ctrl_word;
      SEL_LO:   rd_next = lo_word;
      SEL_HI:   rd_next = hi_word;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? rd_next : '0;
    end
  end

  assert_rd_valid_R9: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  assert_rd_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
endmodule

// File: rtl/wide_snap_counter.sv
module wide_snap_counter
  import wsc_pkg::*;
#(
  parameter int CNT_W       = 64,
  parameter int LATCH_DELAY = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [BUS_W-1:0]  bus_wr_data,
  input  logic              bus_rd_en,
  output logic [BUS_W-1:0]  bus_rd_data,
  output logic              bus_rd_valid
);
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] hold;
  logic             pending;
  logic             req_wr;
  logic             unused_wdata;

  assign unused_wdata = ^{bus_wr_data[BUS_W-1:REQ_BIT+1], bus_wr_data[REQ_BIT-1:0]};

  wsc_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_en(tick_en), .count_q(count)
  );

  wsc_snap_ctrl #(.CNT_W(CNT_W), .LATCH_DELAY(LATCH_DELAY)) u_snap (
    .clk(clk), .rst(rst), .req_wr(req_wr), .count_in(count),
    .pending_q(pending), .hold_q(hold)
  );

  wsc_reg_if #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr_en(bus_wr_en),
    .req_bit(bus_wr_data[REQ_BIT]), .rd_en(bus_rd_en), .pending(pending),
    .hold(hold), .req_wr(req_wr), .rd_data(bus_rd_data), .rd_valid(bus_rd_valid)
  );
endmodule

// File: tb/wide_snap_counter_bench.sv
`timescale 1ns/1ps
module wide_snap_counter_bench;
  localparam int DLY = 2;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd = 1'b0;
  logic [31:0] rdata, s_rdata;
  logic        rvalid, s_rvalid;

  int n_tests = 0;
  int n_fail  = 0;
  int tick_mode = 0;
  longint unsigned m_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wide_snap_counter #(.CNT_W(64), .LATCH_DELAY(DLY)) u_wide_snap_counter (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(addr), .bus_wr_en(wr),
    .bus_wr_data(wdata), .bus_rd_en(rd), .bus_rd_data(rdata), .bus_rd_valid(rvalid));

  wide_snap_counter #(.CNT_W(8), .LATCH_DELAY(1)) u_small (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(addr), .bus_wr_en(wr),
    .bus_wr_data(wdata), .bus_rd_en(rd), .bus_rd_data(s_rdata), .bus_rd_valid(s_rvalid));

  always @(posedge clk) begin
    if (rst) m_cnt <= 0;
    else if (tick_en) m_cnt <= m_cnt + 1;
  end

  initial begin
    forever begin
      @(negedge clk);
      if (tick_mode == 2) tick_en = 1'($urandom % 2);
      else tick_en = (tick_mode == 1);
    end
  end

  task automatic check(input string req, input longint unsigned got, input longint unsigned exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d, output logic [31:0] sd, output logic v);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); d = rdata; sd = s_rdata; v = rvalid; rd = 1'b0;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  // Issues a request and polls the flag back to back; returns expected snapshot and poll hits.
  task automatic latch_poll(output longint unsigned exp, output int ones);
    @(negedge clk); addr = 8'hA0; wdata = 32'h2; wr = 1'b1; exp = m_cnt;
    @(negedge clk); wr = 1'b0; rd = 1'b1;
    ones = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rdata[1]) ones++;
      else break;
    end
    rd = 1'b0;
  endtask

  task automatic read_pair(input bit hi_first, output longint unsigned val);
    logic [31:0] lo, hi, sd; logic v;
    if (hi_first) begin bus_read(8'hA8, hi, sd, v); bus_read(8'hA4, lo, sd, v); end
    else begin bus_read(8'hA4, lo, sd, v); bus_read(8'hA8, hi, sd, v); end
    val = {hi, lo};
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: got %0d cycles expected < 150000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    longint unsigned e1, e2, v;
    int ones;
    logic [31:0] d, sd;
    logic vld;
    void'($urandom(32'h5EED1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    bus_read(8'hA0, d, sd, vld); check("R1 ctrl", d, 0);
    bus_read(8'hA4, d, sd, vld); check("R1 lo", d, 0);
    bus_read(8'hA8, d, sd, vld); check("R1 hi", d, 0);

    // R9: latency, valid, unmapped offset
    bus_read(8'h10, d, sd, vld); check("R9 unmapped", d, 0); check("R9 valid", vld, 1);
    @(negedge clk); check("R9 idle valid", rvalid, 0);

    // R3/R4: first snapshot with steady ticking
    tick_mode = 1; repeat (10) @(negedge clk);
    latch_poll(e1, ones); check("R3 poll count", ones, DLY);
    read_pair(0, v); check("R4 snapshot", v, e1);

    // R2: ticks held off, two snapshots equal
    tick_mode = 0; repeat (2) @(negedge clk);
    latch_poll(e1, ones); read_pair(0, v);
    repeat (7) @(negedge clk);
    latch_poll(e2, ones); read_pair(1, e2);
    check("R2 hold without tick", e2, v);
    check("R2 model agrees", v, e1);

    // R5: halves stable while counter runs, either order
    tick_mode = 1; repeat (9) @(negedge clk);
    read_pair(1, e2); check("R5 stable hi first", e2, v);

    // R6: write with bit 1 clear
    bus_write(8'hA0, 32'hFFFF_FFFD);
    bus_read(8'hA0, d, sd, vld); check("R6 flag stays 0", d[1], 0);
    read_pair(0, e2); check("R6 hold unchanged", e2, v);

    // R7: second request while pending ignored
    @(negedge clk); addr = 8'hA0; wdata = 32'h2; wr = 1'b1; e1 = m_cnt;
    @(negedge clk);
    @(negedge clk); wr = 1'b0; rd = 1'b1;
    ones = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rdata[1]) ones++; else break;
    end
    rd = 1'b0;
    check("R7 poll after busy write", ones, DLY - 1);
    read_pair(0, v); check("R7 first snapshot kept", v, e1);

    // Random ticks with random gaps, random read order
    tick_mode = 2;
    for (int k = 0; k < 30; k++) begin
      repeat ($urandom % 20) @(negedge clk);
      latch_poll(e1, ones);
      check("R3 random poll count", ones, DLY);
      read_pair(1'($urandom % 2), v);
      check("R4 random snapshot", v, e1);
    end

    // R8: narrow instance past its wrap point
    tick_mode = 1; repeat (300) @(negedge clk);
    latch_poll(e1, ones);
    bus_read(8'hA4, d, sd, vld); check("R8 wrapped low byte", sd, e1 & 64'hFF);
    bus_read(8'hA8, d, sd, vld); check("R8 narrow hi zero", sd, 0);
    check("R8 wrap reached", (e1 >= 256) ? 1 : 0, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule